// File: doc/BRIEF.md
# Stereo/TDM Serial Audio Port Transmitter

This block sends parallel audio words as a serial stream on a three-wire bus: a bit clock, a frame clock and one data line. Channel words are presented on a flat parallel input, one field per slot. At every frame start they are copied into a shadow register, so a word is never split across two frames. The block drives data and the frame clock on the configured "launch" edge of the bit clock. A receiver captures them on the opposite edge.

All settings can be changed at run time. They are: clock direction (master or slave), two or four slots per frame, which bit-clock edge launches data, which frame-clock edge marks a frame start, and a frame clock that is either half-frame wide or a single bit wide. In master mode the block divides its system clock to make both bus clocks. In slave mode it brings the external clocks through two-flop synchronizers. It then finds the frame-start edge on the incoming frame clock and realigns its slot counter there. One counter and one shift-select path serve both frame shapes.

Top module: `sap_tx`

## Requirements
- R1: With `master_en`=1, `clk_oe` is 1 and `bclk_o` toggles every `div_half` system clocks, where a value of 0 acts as 1. With `master_en`=0, `clk_oe` is 0.
- R2: Data and frame clock change only on the launch edge of the bit clock. That is the falling edge when `bclk_rise`=0 and the rising edge when `bclk_rise`=1. Neither changes on the other edge or between edges.
- R3: Each slot is 32 bit clocks. `slot_mode`=01 gives 4 slots (128 bit clocks per frame). The codes 00, 10 and 11 give 2 slots (64 bit clocks).
- R4: With `fclk_pulse`=0, the frame clock sits at its start level for the first half of the frame's bit periods and at the opposite level for the second half.
- R5: With `fclk_pulse`=1, the frame clock sits at its start level for bit period 0 only.
- R6: The start level is low when `fclk_rise`=0 (a frame starts on a falling edge) and high when `fclk_rise`=1. During and after reset the frame clock idles at the opposite level.
- R7: Bit period 0 of a frame carries 0. Slot s takes bits `samples[s*SAMPLE_W +: SAMPLE_W]`. Its bit at index SAMPLE_W-1-j goes out in bit period 32*s+j+1 for j < SAMPLE_W, MSB first. The remaining bit periods of the slot carry 0.
- R8: The slot words are captured at the frame start. A change of `samples` later in the frame has no effect on that frame's data.
- R9: In slave mode a frame start is the start-level edge of `fclk_i`, sampled on the non-launch edge of `bclk_i`. The MSB of slot 0 goes out on the next launch edge. Every frame start realigns the frame, including one that arrives before the current frame has ended.
- R10: During reset `sdata_o` is 0 and `bclk_o` is at the level opposite to its launch edge, so the first edge after reset is a launch edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1: block generates bus clocks; 0: bus clocks are inputs |
| slot_mode | input | 2 | 01: four slots; other codes: two slots |
| bclk_rise | input | 1 | Launch edge of bit clock: 0 falling, 1 rising |
| fclk_rise | input | 1 | Frame-start edge of frame clock: 0 falling, 1 rising |
| fclk_pulse | input | 1 | 0: half-frame frame clock; 1: one-bit frame clock |
| div_half | input | DIV_W | System clocks per bit-clock half period in master mode |
| samples | input | 4*SAMPLE_W | Slot words, slot s at bits s*SAMPLE_W upward |
| bclk_i | input | 1 | Bit clock from the bus in slave mode |
| fclk_i | input | 1 | Frame clock from the bus in slave mode |
| bclk_o | output | 1 | Generated bit clock |
| fclk_o | output | 1 | Generated frame clock |
| clk_oe | output | 1 | Output enable for both bus clocks |
| sdata_o | output | 1 | Serial data |

## Verification
The bench builds the block with its default SAMPLE_W of 24 and DIV_W of 8. With 24-bit words each slot has 8 trailing zero bits, so data overrunning its field shows up, and bit period 0 is always zero. In master mode it sweeps every combination of the three polarity and shape controls, all four slot codes (reserved codes included) and half-period divisors 0, 1 and 3. It decodes each frame from the pins and changes the slot words at random during frames. In slave mode it drives the bus clocks itself with an early, cut-short frame followed by full frames. This exercises realignment and capture at the frame start for both frame sizes and all edge settings.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int SLOT_BITS = 32;
    localparam int MAX_SLOTS = 4;
    localparam int SLOT_LSB  = $clog2(SLOT_BITS);
    localparam int CNT_W     = $clog2(SLOT_BITS * MAX_SLOTS);

    typedef logic [CNT_W-1:0] bit_idx_t;
    typedef logic [CNT_W:0]   frame_len_t;

    typedef enum logic [1:0] {
        SLOTS_TWO  = 2'b00,
        SLOTS_FOUR = 2'b01,
        SLOTS_RSV2 = 2'b10,
        SLOTS_RSV3 = 2'b11
    } slot_mode_e;

    typedef struct packed {
        logic master;
        logic pulse;
        logic bclk_rise;
        logic fclk_rise;
        logic four_slot;
    } port_cfg_t;

    typedef struct packed {
        logic launch;
        logic sample;
    } bit_evt_t;

    function automatic logic is_four_slot(input logic [1:0] code);
        return code == SLOTS_FOUR;
    endfunction

    function automatic frame_len_t frame_bits(input logic four_slot);
        return four_slot ? frame_len_t'(SLOT_BITS * 4) : frame_len_t'(SLOT_BITS * 2);
    endfunction

endpackage

// File: rtl/sap_mclk.sv
module sap_mclk
    import sap_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_half,
    output logic             ph,
    output bit_evt_t         evt
);

    logic [DIV_W-1:0] divcnt;
    logic [DIV_W-1:0] lim;
    logic             tick;

    assign lim  = (div_half == '0) ? '0 : div_half - 1'b1;
    assign tick = en && (divcnt >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            divcnt <= '0;
            ph     <= 1'b0;
        end else if (!en) begin
            divcnt <= '0;
            ph     <= 1'b0;
        end else if (tick) begin
            divcnt <= '0;
            ph     <= ~ph;
        end else begin
            divcnt <= divcnt + 1'b1;
        end
    end

    assign evt.launch = tick && !ph;
    assign evt.sample = tick && ph;

    AST_PH_PARKED: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ph && divcnt == '0)); // R1

endmodule

// File: rtl/sap_sync.sv
module sap_sync
    import sap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     bclk_rise,
    input  logic     bclk_i,
    input  logic     fclk_i,
    output bit_evt_t evt,
    output logic     fclk_lvl
);

    logic [2:0] bsh;
    logic [1:0] fsh;
    logic       changed;

    always_ff @(posedge clk) begin
        if (rst) begin
            bsh <= '0;
            fsh <= '0;
        end else begin
            bsh <= {bsh[1:0], bclk_i};
            fsh <= {fsh[0], fclk_i};
        end
    end

    assign changed    = en && (bsh[1] != bsh[2]);
    assign evt.launch = changed && (bsh[1] == bclk_rise);
    assign evt.sample = changed && (bsh[1] != bclk_rise);
    assign fclk_lvl   = fsh[1];

    AST_SYNC_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.launch, evt.sample})); // R9

endmodule

// File: rtl/sap_engine.sv
module sap_engine
    import sap_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  port_cfg_t                     cfg,
    input  bit_evt_t                      evt,
    input  logic                          fclk_lvl,
    input  logic [MAX_SLOTS*SAMPLE_W-1:0] samples,
    output logic                          sdata,
    output logic                          fclk_act
);

    localparam int BUS_W = MAX_SLOTS * SAMPLE_W;
    localparam int IDX_W = $clog2(BUS_W);

    bit_idx_t               cnt;
    frame_len_t             flen;
    logic                   fprev;
    logic                   fstart;
    logic                   latch;
    logic [BUS_W-1:0]       shadow;
    logic                   nxt_bit;
    bit_idx_t               q;
    logic [CNT_W-SLOT_LSB-1:0] slot;
    logic [SLOT_LSB-1:0]    j;
    logic [IDX_W-1:0]       idx;

    assign flen   = frame_bits(cfg.four_slot);
    assign fstart = !cfg.master && evt.sample &&
                    (fclk_lvl == cfg.fclk_rise) && (fprev != cfg.fclk_rise);
    assign latch  = cfg.master ? (evt.launch && cnt == '0) : fstart;

    always_comb begin
        q       = cnt - 1'b1;
        slot    = q[CNT_W-1:SLOT_LSB];
        j       = q[SLOT_LSB-1:0];
        idx     = IDX_W'(int'(slot) * SAMPLE_W + SAMPLE_W - 1 - int'(j));
        nxt_bit = 1'b0;
        if (cnt != '0 && int'(j) < SAMPLE_W) begin
            nxt_bit = shadow[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            sdata    <= 1'b0;
            fclk_act <= 1'b0;
            fprev    <= 1'b0;
            shadow   <= '0;
        end else begin
            if (evt.sample) begin
                fprev <= fclk_lvl;
            end
            if (latch) begin
                shadow <= samples;
            end
            if (evt.launch) begin
                sdata <= nxt_bit;
                if (cfg.master) begin
                    fclk_act <= cfg.pulse ? (cnt == '0) : ({1'b0, cnt} < (flen >> 1));
                end
            end
            if (fstart) begin
                cnt <= bit_idx_t'(1);
            end else if (evt.launch) begin
                cnt <= ({1'b0, cnt} >= flen - 1'b1) ? '0 : cnt + 1'b1;
            end
        end
    end

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cnt} < flen); // R3
    AST_SDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !evt.launch |=> $stable(sdata)); // R2
    AST_GAP_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        (evt.launch && cnt == '0) |=> !sdata); // R7
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(shadow)); // R8
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
        (cfg.master && cfg.pulse && evt.launch && cnt != '0) |=> !fclk_act); // R5
    AST_SLAVE_REALIGN: assert property (@(posedge clk) disable iff (rst)
        fstart |=> (cnt == bit_idx_t'(1))); // R9

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int DIV_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          master_en,
    input  logic [1:0]                    slot_mode,
    input  logic                          bclk_rise,
    input  logic                          fclk_rise,
    input  logic                          fclk_pulse,
    input  logic [DIV_W-1:0]              div_half,
    input  logic [MAX_SLOTS*SAMPLE_W-1:0] samples,
    input  logic                          bclk_i,
    input  logic                          fclk_i,
    output logic                          bclk_o,
    output logic                          fclk_o,
    output logic                          clk_oe,
    output logic                          sdata_o
);

    port_cfg_t cfg;
    bit_evt_t  evt_m;
    bit_evt_t  evt_s;
    bit_evt_t  evt;
    logic      bph;
    logic      fclk_lvl;
    logic      fact;

    assign cfg.master    = master_en;
    assign cfg.pulse     = fclk_pulse;
    assign cfg.bclk_rise = bclk_rise;
    assign cfg.fclk_rise = fclk_rise;
    assign cfg.four_slot = is_four_slot(slot_mode);

    sap_mclk #(.DIV_W(DIV_W)) u_mclk (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg.master),
        .div_half (div_half),
        .ph       (bph),
        .evt      (evt_m)
    );

    sap_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .en        (!cfg.master),
        .bclk_rise (cfg.bclk_rise),
        .bclk_i    (bclk_i),
        .fclk_i    (fclk_i),
        .evt       (evt_s),
        .fclk_lvl  (fclk_lvl)
    );

    assign evt = cfg.master ? evt_m : evt_s;

    sap_engine #(.SAMPLE_W(SAMPLE_W)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .evt      (evt),
        .fclk_lvl (fclk_lvl),
        .samples  (samples),
        .sdata    (sdata_o),
        .fclk_act (fact)
    );

    assign bclk_o = cfg.bclk_rise ? bph : ~bph;
    assign fclk_o = cfg.fclk_rise ? fact : ~fact;
    assign clk_oe = cfg.master;

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(evt.launch && evt.sample)); // R2

endmodule

// File: tb/sap_tx_bench.sv
module sap_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SW         = 24;
    localparam int DW         = 8;
    localparam int BUS        = 4 * SW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           master_en = 1'b1;
    logic [1:0]     slot_mode = 2'b00;
    logic           bclk_rise = 1'b0;
    logic           fclk_rise = 1'b0;
    logic           fclk_pulse = 1'b0;
    logic [DW-1:0]  div_half = 8'd1;
    logic [BUS-1:0] samples = '0;
    logic           bclk_i = 1'b0;
    logic           fclk_i = 1'b0;
    logic           bclk_o;
    logic           fclk_o;
    logic           clk_oe;
    logic           sdata_o;

    int tests = 0;
    int fails = 0;
    logic [BUS-1:0] exp_sh = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sap_tx #(.SAMPLE_W(SW), .DIV_W(DW)) u_sap_tx (
        .clk(clk), .rst(rst), .master_en(master_en), .slot_mode(slot_mode),
        .bclk_rise(bclk_rise), .fclk_rise(fclk_rise), .fclk_pulse(fclk_pulse),
        .div_half(div_half), .samples(samples), .bclk_i(bclk_i), .fclk_i(fclk_i),
        .bclk_o(bclk_o), .fclk_o(fclk_o), .clk_oe(clk_oe), .sdata_o(sdata_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int p);
        int qq, s, jj;
        if (p == 0) return 1'b0;
        qq = p - 1;
        s  = qq / 32;
        jj = qq % 32;
        if (jj >= SW) return 1'b0;
        return exp_sh[s*SW + SW - 1 - jj];
    endfunction

    task automatic scramble();
        for (int s = 0; s < 4; s++) samples[s*SW +: SW] = SW'($urandom);
    endtask

    task automatic do_reset(input bit ms, input bit bp, input bit lp, input bit pu,
                            input logic [1:0] sm, input int h);
        rst        = 1'b1;
        master_en  = ms;
        bclk_rise  = bp;
        fclk_rise  = lp;
        fclk_pulse = pu;
        slot_mode  = sm;
        div_half   = DW'(h);
        bclk_i     = ~bp;
        fclk_i     = ~lp;
        repeat (3) @(negedge clk);
        check(sdata_o == 1'b0, "R10 reset sdata", int'(sdata_o), 0);
        if (ms) begin
            check(bclk_o == ~bp, "R10 reset bclk level", int'(bclk_o), int'(~bp));
            check(fclk_o == ~lp, "R6 reset fclk level", int'(fclk_o), int'(~lp));
        end
        check(clk_oe == ms, "R1 clock direction", int'(clk_oe), int'(ms));
        rst = 1'b0;
    endtask

    task automatic run_master(input bit bp, input bit lp, input bit pu,
                              input logic [1:0] sm, input int h);
        int  n    = (sm == 2'b01) ? 128 : 64;
        int  heff = (h == 0) ? 1 : h;
        int  hc = 0, edges = 0, lc = 0, starts = 0, guard = 0;
        bit  started = 0;
        logic pb, pf, pd, b, f, d, act;
        do_reset(1'b1, bp, lp, pu, sm, h);
        pb = bclk_o; pf = fclk_o; pd = sdata_o;
        while (starts < 3 && guard < 4 * n * 2 * heff + 64) begin
            @(negedge clk);
            guard++;
            hc++;
            b = bclk_o; f = fclk_o; d = sdata_o;
            if (b != pb) begin
                if (edges > 0) check(hc == heff, "R1 half period", hc, heff);
                edges++;
                hc = 0;
                if (b == bp) begin
                    if (f == lp && pf != lp) begin
                        if (started) check(lc + 1 == n, "R3 frame length", lc + 1, n);
                        started = 1;
                        starts++;
                        lc = 0;
                        exp_sh = samples;
                    end else if (started) begin
                        lc++;
                    end
                    if (started) begin
                        act = pu ? (lc == 0) : (lc < n / 2);
                        check(f == (act ? lp : ~lp), pu ? "R5 pulse frame clock" : "R4 half frame clock",
                              int'(f), int'(act ? lp : ~lp));
                        check(d == exp_bit(lc), "R7 data bit", int'(d), int'(exp_bit(lc)));
                    end
                end else if (started) begin
                    check(d == pd && f == pf, "R2 change on capture edge", int'({d, f}), int'({pd, pf}));
                end
            end else if (started && (d != pd || f != pf)) begin
                check(1'b0, "R2 change between edges", int'({d, f}), int'({pd, pf}));
            end
            pb = b; pf = f; pd = d;
            if ((guard % 29) == 0) scramble();
        end
        check(starts == 3, "R6 frame starts seen", starts, 3);
    endtask

    task automatic sbit(input bit bp, input logic fc, input bit chk, input logic e, input string tag);
        @(negedge clk);
        bclk_i = bp;
        fclk_i = fc;
        repeat (4) @(negedge clk);
        if (chk) check(sdata_o == e, tag, int'(sdata_o), int'(e));
        bclk_i = ~bp;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_slave(input bit bp, input bit lp, input bit pu, input logic [1:0] sm);
        int n = (sm == 2'b01) ? 128 : 64;
        int tl = 21;
        logic act;
        do_reset(1'b0, bp, lp, pu, sm, 1);
        scramble();
        for (int i = 0; i < 4; i++) sbit(bp, ~lp, 1'b0, 1'b0, "");
        for (int p = 0; p < tl; p++) begin
            act = pu ? (p == 0) : (p < tl / 2);
            if (p == 0) exp_sh = samples;
            sbit(bp, act ? lp : ~lp, p >= 1, exp_bit(p), "R9 early frame data");
        end
        for (int fr = 0; fr < 2; fr++) begin
            for (int p = 0; p < n; p++) begin
                act = pu ? (p == 0) : (p < n / 2);
                if (p == 0) exp_sh = samples;
                if (p == n / 2) scramble();
                sbit(bp, act ? lp : ~lp, (p >= 1) || (fr == 1), exp_bit(p),
                     (p > n / 2) ? "R8 data after word change" : "R9 realigned data");
            end
        end
        check(clk_oe == 1'b0, "R1 slave clock direction", int'(clk_oe), 0);
    endtask

    initial begin
        repeat (200000 - 10000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hv[3] = '{0, 1, 3};
        for (int c = 0; c < 32; c++) begin
            for (int k = 0; k < 3; k++) begin
                scramble();
                run_master(c[0], c[1], c[2], c[4:3], hv[k]);
            end
        end
        for (int c = 0; c < 16; c++) begin
            run_slave(c[0], c[1], c[2], {1'b0, c[3]});
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule